// File: doc/BRIEF.md
# Clock Root Configuration Register Bank

This block is the software-facing control point of one clock root. A plain 32-bit read/write port reaches a command register, a configuration register and three counter registers (M, N and D). Software writes only staged copies of these registers. The source select, pre-divider, mode, hardware-control flag and counter values that drive the downstream divider and mux change only when software requests a commit. The requested commit is then carried out a fixed number of cycles later. The block also reports, in the command register, whether the clock root is switched off.

A commit starts when software writes 1 to the update flag. The flag reads as 1 while the commit is in flight. The block clears the flag in the same clock edge that copies the staged registers to the active outputs, so software polls the flag and treats 0 as "new settings in force". A small state machine runs the commit. State ST_IDLE waits. Transition START (update write seen in ST_IDLE) enters ST_PENDING with the cycle counter at 0. Transition COUNT stays in ST_PENDING and advances the counter. Transition FINISH (counter at its last value) asserts the one-cycle commit strobe and returns to ST_IDLE.

Register map, in byte addresses: the command register is at 0x00. The configuration register is at CFG_OFS+0x04, M at CFG_OFS+0x08, N at CFG_OFS+0x0C and D at CFG_OFS+0x10. Reads are registered: bus_rdata and bus_rd_valid appear one cycle after bus_rd_en.

Top module: `clkroot_regbank`

## Requirements
- R1: After reset, every active output is 0, the update flag reads 0, and the configuration, M, N and D registers read 0.
- R2: Each register reads back exactly the value written in its implemented bits. Unimplemented bits read 0: in M, N and D these are bits 31 down to CNT_W.
- R3: Writes to the configuration, M, N or D registers leave every active output unchanged until a commit completes.
- R4: A write to the command register with bit 0 set, made while no commit is pending, makes command bit 0 read as 1 from the next cycle until the commit completes.
- R5: The commit lands on the COMMIT_CYC-th rising edge after the edge that accepted the update write. On that edge every active output takes its staged value and command bit 0 returns to 0.
- R6: A write made while a commit is pending changes only the staged registers. A further update write does not restart or extend the pending commit. The commit copies the staged values as they stand at its completion edge.
- R7: Command bit 31 reflects the root_off_i input and cannot be written.
- R8: A command write with bit 0 clear starts no commit.
- R9: Writes to addresses outside the map change nothing, and reads of such addresses return 0.
- R10: The configuration fields sit at these bit positions: pre-divider [PDIV_W-1:0], source select [8+SRC_W-1:8], mode [12+MODE_W-1:12], hardware control [20].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd_en |
| bus_rd_valid | output | 1 | Marks bus_rdata valid |
| root_off_i | input | 1 | Clock root disabled status |
| act_src | output | SRC_W | Active source select |
| act_pdiv | output | PDIV_W | Active pre-divider (0 = bypass) |
| act_mode | output | MODE_W | Active counter mode |
| act_hwctl | output | 1 | Active hardware clock control flag |
| act_m | output | CNT_W | Active M value |
| act_n | output | CNT_W | Active N value |
| act_d | output | CNT_W | Active D value |

## Verification
The bench builds the bank with CFG_OFS=0x40, CNT_W=10, PDIV_W=4 and COMMIT_CYC=3. The nonzero offset puts the old zero-offset addresses outside the map, so a write there must fall through as unmapped. The odd counter width shows the masking of unimplemented bits above bit 9. The short commit window lets the bench place a write and a second update request inside a pending commit, and check edge by edge that the outputs move on exactly the third edge.

// File: rtl/clkroot_pkg.sv
package clkroot_pkg;

    // Commit sequencer states
    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_PENDING = 1'b1
    } commit_state_e;

    // Counter register slots (M, N, D) in address order
    localparam int unsigned NUM_CNT_REGS = 3;

    // Configuration field positions (read-modify-write layout)
    localparam int unsigned SRC_LSB  = 8;
    localparam int unsigned MODE_LSB = 12;
    localparam int unsigned HW_BIT   = 20;

    // Address offsets relative to CFG_OFS
    localparam int unsigned CFG_REL  = 4;
    localparam int unsigned CNT_REL  = 8;
    localparam int unsigned CNT_STEP = 4;

endpackage

// File: rtl/clkroot_shadow.sv
module clkroot_shadow
    import clkroot_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned CFG_OFS = 0,
    parameter int unsigned PDIV_W  = 5,
    parameter int unsigned SRC_W   = 3,
    parameter int unsigned MODE_W  = 2,
    parameter int unsigned CNT_W   = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [ADDR_W-1:0]                     addr,
    input  logic [31:0]                           wdata,
    output logic [SRC_W-1:0]                      sh_src,
    output logic [PDIV_W-1:0]                     sh_pdiv,
    output logic [MODE_W-1:0]                     sh_mode,
    output logic                                  sh_hw,
    output logic [NUM_CNT_REGS-1:0][CNT_W-1:0]    sh_cnt
);

    localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(CFG_OFS + CFG_REL);

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_src  <= '0;
            sh_pdiv <= '0;
            sh_mode <= '0;
            sh_hw   <= 1'b0;
        end else if (wr_en && addr == CFG_ADDR) begin
            sh_pdiv <= wdata[PDIV_W-1:0];
            sh_src  <= wdata[SRC_LSB +: SRC_W];
            sh_mode <= wdata[MODE_LSB +: MODE_W];
            sh_hw   <= wdata[HW_BIT];
        end
    end

    for (genvar g = 0; g < NUM_CNT_REGS; g++) begin : g_cnt
        localparam logic [ADDR_W-1:0] SLOT_ADDR =
            ADDR_W'(CFG_OFS + CNT_REL + CNT_STEP * g);
        logic [CNT_W-1:0] slot_q;

        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q <= '0;
            else if (wr_en && addr == SLOT_ADDR)
                slot_q <= wdata[CNT_W-1:0];
        end

        assign sh_cnt[g] = slot_q;
    end

endmodule

// File: rtl/clkroot_commit_fsm.sv
module clkroot_commit_fsm
    import clkroot_pkg::*;
#(
    parameter int unsigned COMMIT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_req,
    output logic busy,
    output logic commit
);

    localparam int unsigned CW = $clog2(COMMIT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(COMMIT_CYC - 1);

    commit_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Transitions: START, COUNT, FINISH
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (upd_req) begin
                    st_d  = ST_PENDING;
                    cnt_d = '0;
                end
            end
            ST_PENDING: begin
                if (cnt_q == LAST) begin
                    st_d  = ST_IDLE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                st_d  = ST_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        busy   = 1'b0;
        commit = 1'b0;
        unique case (st_q)
            ST_IDLE:    ;
            ST_PENDING: begin
                busy   = 1'b1;
                commit = (cnt_q == LAST);
            end
            default:    ;
        endcase
    end

endmodule

// File: rtl/clkroot_active.sv
module clkroot_active
    import clkroot_pkg::*;
#(
    parameter int unsigned PDIV_W = 5,
    parameter int unsigned SRC_W  = 3,
    parameter int unsigned MODE_W = 2,
    parameter int unsigned CNT_W  = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               commit,
    input  logic [SRC_W-1:0]                   sh_src,
    input  logic [PDIV_W-1:0]                  sh_pdiv,
    input  logic [MODE_W-1:0]                  sh_mode,
    input  logic                               sh_hw,
    input  logic [NUM_CNT_REGS-1:0][CNT_W-1:0] sh_cnt,
    output logic [SRC_W-1:0]                   act_src,
    output logic [PDIV_W-1:0]                  act_pdiv,
    output logic [MODE_W-1:0]                  act_mode,
    output logic                               act_hw,
    output logic [NUM_CNT_REGS-1:0][CNT_W-1:0] act_cnt
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_src  <= '0;
            act_pdiv <= '0;
            act_mode <= '0;
            act_hw   <= 1'b0;
            act_cnt  <= '0;
        end else if (commit) begin
            act_src  <= sh_src;
            act_pdiv <= sh_pdiv;
            act_mode <= sh_mode;
            act_hw   <= sh_hw;
            act_cnt  <= sh_cnt;
        end
    end

endmodule

// File: rtl/clkroot_readmux.sv
module clkroot_readmux
    import clkroot_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned CFG_OFS = 0,
    parameter int unsigned PDIV_W  = 5,
    parameter int unsigned SRC_W   = 3,
    parameter int unsigned MODE_W  = 2,
    parameter int unsigned CNT_W   = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               rd_en,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic                               busy,
    input  logic                               root_off,
    input  logic [SRC_W-1:0]                   sh_src,
    input  logic [PDIV_W-1:0]                  sh_pdiv,
    input  logic [MODE_W-1:0]                  sh_mode,
    input  logic                               sh_hw,
    input  logic [NUM_CNT_REGS-1:0][CNT_W-1:0] sh_cnt,
    output logic [31:0]                        rdata,
    output logic                               rd_valid
);

    localparam logic [ADDR_W-1:0] CMD_ADDR = '0;
    localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(CFG_OFS + CFG_REL);

    logic [31:0] cfg_word;
    logic [31:0] word_d;

    always_comb begin
        cfg_word = '0;
        cfg_word[PDIV_W-1:0]          = sh_pdiv;
        cfg_word[SRC_LSB +: SRC_W]    = sh_src;
        cfg_word[MODE_LSB +: MODE_W]  = sh_mode;
        cfg_word[HW_BIT]              = sh_hw;
    end

    always_comb begin
        word_d = '0;
        if (addr == CMD_ADDR) begin
            word_d[0]  = busy;
            word_d[31] = root_off;
        end else if (addr == CFG_ADDR) begin
            word_d = cfg_word;
        end else begin
            for (int i = 0; i < NUM_CNT_REGS; i++) begin
                if (addr == ADDR_W'(CFG_OFS + CNT_REL + CNT_STEP * i))
                    word_d = 32'(sh_cnt[i]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en)
                rdata <= word_d;
        end
    end

endmodule

// File: rtl/clkroot_regbank.sv
module clkroot_regbank
    import clkroot_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned CFG_OFS    = 0,
    parameter int unsigned PDIV_W     = 5,
    parameter int unsigned SRC_W      = 3,
    parameter int unsigned MODE_W     = 2,
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned COMMIT_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rd_valid,
    input  logic              root_off_i,
    output logic [SRC_W-1:0]  act_src,
    output logic [PDIV_W-1:0] act_pdiv,
    output logic [MODE_W-1:0] act_mode,
    output logic              act_hwctl,
    output logic [CNT_W-1:0]  act_m,
    output logic [CNT_W-1:0]  act_n,
    output logic [CNT_W-1:0]  act_d
);

    logic [SRC_W-1:0]                   sh_src;
    logic [PDIV_W-1:0]                  sh_pdiv;
    logic [MODE_W-1:0]                  sh_mode;
    logic                               sh_hw;
    logic [NUM_CNT_REGS-1:0][CNT_W-1:0] sh_cnt;
    logic [NUM_CNT_REGS-1:0][CNT_W-1:0] act_cnt;
    logic                               upd_req;
    logic                               upd_busy;
    logic                               upd_commit;

    assign upd_req = bus_wr_en && (bus_addr == '0) && bus_wdata[0];

    clkroot_shadow #(
        .ADDR_W(ADDR_W), .CFG_OFS(CFG_OFS), .PDIV_W(PDIV_W),
        .SRC_W(SRC_W), .MODE_W(MODE_W), .CNT_W(CNT_W)
    ) u_shadow (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .addr(bus_addr),
        .wdata(bus_wdata), .sh_src(sh_src), .sh_pdiv(sh_pdiv),
        .sh_mode(sh_mode), .sh_hw(sh_hw), .sh_cnt(sh_cnt)
    );

    clkroot_commit_fsm #(
        .COMMIT_CYC(COMMIT_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .upd_req(upd_req),
        .busy(upd_busy), .commit(upd_commit)
    );

    clkroot_active #(
        .PDIV_W(PDIV_W), .SRC_W(SRC_W), .MODE_W(MODE_W), .CNT_W(CNT_W)
    ) u_active (
        .clk(clk), .rst_n(rst_n), .commit(upd_commit),
        .sh_src(sh_src), .sh_pdiv(sh_pdiv), .sh_mode(sh_mode),
        .sh_hw(sh_hw), .sh_cnt(sh_cnt),
        .act_src(act_src), .act_pdiv(act_pdiv), .act_mode(act_mode),
        .act_hw(act_hwctl), .act_cnt(act_cnt)
    );

    clkroot_readmux #(
        .ADDR_W(ADDR_W), .CFG_OFS(CFG_OFS), .PDIV_W(PDIV_W),
        .SRC_W(SRC_W), .MODE_W(MODE_W), .CNT_W(CNT_W)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(bus_rd_en), .addr(bus_addr),
        .busy(upd_busy), .root_off(root_off_i),
        .sh_src(sh_src), .sh_pdiv(sh_pdiv), .sh_mode(sh_mode),
        .sh_hw(sh_hw), .sh_cnt(sh_cnt),
        .rdata(bus_rdata), .rd_valid(bus_rd_valid)
    );

    assign act_m = act_cnt[0];
    assign act_n = act_cnt[1];
    assign act_d = act_cnt[2];

endmodule

// File: rtl/clkroot_regbank_chk.sv
module clkroot_regbank_chk #(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned CFG_OFS    = 0,
    parameter int unsigned PDIV_W     = 5,
    parameter int unsigned SRC_W      = 3,
    parameter int unsigned MODE_W     = 2,
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned COMMIT_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic              bus_rd_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              upd_busy,
    input logic [SRC_W-1:0]  act_src,
    input logic [PDIV_W-1:0] act_pdiv,
    input logic [MODE_W-1:0] act_mode,
    input logic              act_hwctl,
    input logic [CNT_W-1:0]  act_m,
    input logic [CNT_W-1:0]  act_n,
    input logic [CNT_W-1:0]  act_d
);

    localparam logic [ADDR_W-1:0] M_ADDR = ADDR_W'(CFG_OFS + 8);

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata;

    logic [31:0] busy_cycles;
    always_ff @(posedge clk) begin
        if (!rst_n)        busy_cycles <= '0;
        else if (upd_busy) busy_cycles <= busy_cycles + 1;
        else               busy_cycles <= '0;
    end

    // R3
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(upd_busy) |-> $stable({act_src, act_pdiv, act_mode, act_hwctl,
                                      act_m, act_n, act_d}));

    // R4
    update_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == '0 && bus_wdata[0] && !upd_busy) |=> upd_busy);

    // R5
    commit_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(upd_busy) |-> (busy_cycles == COMMIT_CYC));

    // R6
    no_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_busy |-> (busy_cycles < COMMIT_CYC));

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr == M_ADDR) |=> (bus_rdata[31:CNT_W] == '0));

endmodule

bind clkroot_regbank clkroot_regbank_chk #(
    .ADDR_W(ADDR_W), .CFG_OFS(CFG_OFS), .PDIV_W(PDIV_W), .SRC_W(SRC_W),
    .MODE_W(MODE_W), .CNT_W(CNT_W), .COMMIT_CYC(COMMIT_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .upd_busy(upd_busy), .act_src(act_src), .act_pdiv(act_pdiv),
    .act_mode(act_mode), .act_hwctl(act_hwctl), .act_m(act_m),
    .act_n(act_n), .act_d(act_d)
);

// File: tb/clkroot_regbank_bench.sv
module clkroot_regbank_bench;

    localparam int ADDR_W = 8;
    localparam int CFG_OFS = 'h40;
    localparam int PDIV_W = 4;
    localparam int SRC_W = 3;
    localparam int MODE_W = 2;
    localparam int CNT_W = 10;
    localparam int COMMIT_CYC = 3;

    localparam logic [7:0] A_CMD = 8'h00;
    localparam logic [7:0] A_CFG = 8'h44;
    localparam logic [7:0] A_M   = 8'h48;
    localparam logic [7:0] A_N   = 8'h4C;
    localparam logic [7:0] A_D   = 8'h50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr_en = 1'b0, bus_rd_en = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic bus_rd_valid;
    logic root_off_i = 1'b0;
    logic [SRC_W-1:0] act_src;
    logic [PDIV_W-1:0] act_pdiv;
    logic [MODE_W-1:0] act_mode;
    logic act_hwctl;
    logic [CNT_W-1:0] act_m, act_n, act_d;

    always #5 clk = ~clk;

    clkroot_regbank #(
        .ADDR_W(ADDR_W), .CFG_OFS(CFG_OFS), .PDIV_W(PDIV_W), .SRC_W(SRC_W),
        .MODE_W(MODE_W), .CNT_W(CNT_W), .COMMIT_CYC(COMMIT_CYC)
    ) u_clkroot_regbank (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rd_valid(bus_rd_valid), .root_off_i(root_off_i),
        .act_src(act_src), .act_pdiv(act_pdiv), .act_mode(act_mode),
        .act_hwctl(act_hwctl), .act_m(act_m), .act_n(act_n), .act_d(act_d)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    // expected active state
    logic [31:0] e_src = 0, e_pdiv = 0, e_mode = 0, e_hw = 0;
    logic [31:0] e_m = 0, e_n = 0, e_d = 0;

    function automatic void check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, expv);
        end
    endfunction

    // monitor: pops expected read data as results appear
    always @(negedge clk) begin
        if (bus_rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard-empty", bus_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bus_rdata == e, t, bus_rdata, e);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string t);
        bus_rd_en = 1'b1; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        tick();
        bus_rd_en = 1'b0;
    endtask

    task automatic check_act(input string t);
        logic [31:0] a, e;
        a = {act_src, act_pdiv, act_mode, act_hwctl};
        e = {e_src[SRC_W-1:0], e_pdiv[PDIV_W-1:0], e_mode[MODE_W-1:0], e_hw[0]};
        check(a == e, {t, " cfg outputs"}, a, e);
        check(act_m == e_m[CNT_W-1:0], {t, " act_m"}, 32'(act_m), e_m);
        check(act_n == e_n[CNT_W-1:0], {t, " act_n"}, 32'(act_n), e_n);
        check(act_d == e_d[CNT_W-1:0], {t, " act_d"}, 32'(act_d), e_d);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 32'h0, 32'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check_act("R1 reset");
        bus_read(A_CMD, 32'h0, "R1 cmd");
        bus_read(A_CFG, 32'h0, "R1 cfg");
        bus_read(A_M, 32'h0, "R1 m");
        bus_read(A_N, 32'h0, "R1 n");
        bus_read(A_D, 32'h0, "R1 d");

        // R2 / R10 readback with implemented mask
        bus_write(A_CFG, 32'hFFFF_FFFF);
        bus_read(A_CFG, 32'h0010_370F, "R2 R10 cfg mask");
        bus_write(A_CFG, 32'h0010_2509);
        bus_read(A_CFG, 32'h0010_2509, "R2 cfg value");
        bus_write(A_M, 32'hFFFF_FFFF);
        bus_write(A_N, 32'h0001_2345);
        bus_write(A_D, 32'h0000_0ABC);
        bus_read(A_M, 32'h0000_03FF, "R2 m mask");
        bus_read(A_N, 32'h0000_0345, "R2 n mask");
        bus_read(A_D, 32'h0000_02BC, "R2 d mask");
        check_act("R3 staged only");

        // R4 / R5 commit timing
        bus_write(A_CMD, 32'h1);            // accepted at edge e0
        bus_read(A_CMD, 32'h1, "R4 busy");  // sampled at e1
        check_act("R5 before e2");
        tick();
        check_act("R5 before e3");
        tick();
        e_src = 5; e_pdiv = 9; e_mode = 2; e_hw = 1;
        e_m = 'h3FF; e_n = 'h345; e_d = 'h2BC;
        check_act("R5 R10 after commit");
        bus_read(A_CMD, 32'h0, "R5 cleared");

        // R6 write and update during pending commit
        bus_write(A_M, 32'h155);
        bus_write(A_CMD, 32'h1);            // e0
        bus_write(A_M, 32'h2AA);            // e1
        bus_write(A_CMD, 32'h1);            // e2, ignored
        check_act("R6 before commit");
        tick();                             // e3
        e_m = 'h2AA;
        check_act("R6 commit on time");
        bus_read(A_CMD, 32'h0, "R6 not extended");

        // R8 update bit clear starts nothing
        bus_write(A_CFG, 32'h0000_0301);
        bus_write(A_CMD, 32'h0);
        repeat (6) tick();
        check_act("R8 no commit");
        bus_read(A_CMD, 32'h0, "R8 cmd");
        bus_read(A_CFG, 32'h0000_0301, "R8 cfg staged");

        // R7 root off status
        root_off_i = 1'b1;
        tick();
        bus_read(A_CMD, 32'h8000_0000, "R7 root off");
        bus_write(A_CMD, 32'h8000_0000);
        repeat (5) tick();
        check_act("R7 write ignored");
        root_off_i = 1'b0;
        tick();
        bus_read(A_CMD, 32'h0, "R7 root on");

        // R9 unmapped addresses
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_read(8'h04, 32'h0, "R9 unmapped read");
        bus_read(8'h08, 32'h0, "R9 unmapped read 2");
        bus_read(A_CFG, 32'h0000_0301, "R9 cfg untouched");
        bus_read(A_M, 32'h0000_02AA, "R9 m untouched");
        check_act("R9 outputs");

        // second commit pattern (R10)
        bus_write(A_CMD, 32'h1);
        repeat (COMMIT_CYC) tick();
        e_src = 3; e_pdiv = 1; e_mode = 0; e_hw = 0;
        check_act("R10 second pattern");

        repeat (3) tick();
        check(exp_q.size() == 0, "scoreboard-drain", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule